// File: doc/BRIEF.md
# Branch Resolution Unit

This block resolves one branch instruction per strobe. It takes a 32-bit branch word, the address that word was fetched from, and the current counter, link and condition registers. It decides whether the branch is taken, forms the target address, works out the counter value after an optional decrement, and produces a link-register write of the return address. It also gives a static prediction hint. Three instruction shapes are handled: a direct branch with a wide immediate offset, a conditional branch with a short offset, and a conditional branch whose target comes from the link or counter register.

A five-bit options field in the conditional forms picks the test. That test can decrement the counter and check it for zero or non-zero. It can check one condition-register bit for true or false, or it can branch always. One spare bit of that field reverses the static prediction. Every result is registered and appears one cycle after the input strobe, marked by an output strobe. Bit positions below use the hardware convention: bit 31 is the most significant bit of the word.

Top module: `bru_unit`

## Requirements
- R1: After a synchronous reset, out_valid, taken, ctr_we, lr_we and illegal are all 0. In any cycle where out_valid is 0, taken, ctr_we, lr_we and illegal are 0.
- R2: out_valid is 1 exactly one cycle after in_valid is 1, and the other outputs in that cycle describe the instruction captured with that strobe.
- R3: The direct form has insn[31:26]=18. Its 24-bit word offset is in insn[25:2], the absolute flag in insn[1] and the link flag in insn[0]. It is always taken and predicted taken, and it never touches the counter. Its target is pc plus the sign-extended offset times 4, or the sign-extended offset times 4 alone when the absolute flag is 1.
- R4: The conditional form has insn[31:26]=16. The options field is in insn[25:21], the bit selector in insn[20:16] and a 14-bit word offset in insn[15:2], with the flags in insn[1:0] as in R3. Its target is formed as in R3 from the 14-bit offset.
- R5: When the options field's middle bit (insn[23]) is 0, the counter is decremented. The block then sets ctr_we=1 and ctr_new=ctr-1, wrapping at zero, and the counter test uses the decremented value. When insn[23] is 1, ctr_we=0 and ctr_new=ctr.
- R6: When the options field's top bit (insn[25]) is 0, the branch also needs condition-register bit cr[31-BI] to equal insn[24]. When insn[25] is 1, the condition register is ignored.
- R7: In a decrementing test, insn[22]=0 needs a non-zero counter after the decrement, and insn[22]=1 needs a zero counter.
- R8: When the link flag insn[0] is 1 and the instruction is legal, lr_we=1 and lr_data=pc+4, whether the branch is taken or not.
- R9: The register form has insn[31:26]=19 and insn[15:11]=0. A sub-code insn[10:1]=16 branches to the link register and insn[10:1]=528 branches to the counter register. In both cases the two low bits of the register are cleared. The link-register value from before any link write is the one used.
- R10: The block sets illegal=1, with taken, ctr_we and lr_we all 0, in three cases: a register-to-counter branch with insn[23]=0, any other major opcode, and a register form with an unknown sub-code or a non-zero insn[15:11].
- R11: The predict output is 1 for the direct form and for any options field with insn[25]=1 and insn[23]=1. In all other cases it is the hint bit insn[21] XOR'd with a base value. That base is the sign of the offset for the conditional form and 0 for the register forms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and register inputs are valid this cycle |
| insn | input | 32 | Branch instruction word |
| pc | input | 32 | Address of the branch instruction |
| ctr | input | 32 | Current counter register |
| lr | input | 32 | Current link register |
| cr | input | 32 | Condition register |
| out_valid | output | 1 | Results valid this cycle |
| taken | output | 1 | Branch is taken |
| target | output | 32 | Branch target address |
| ctr_new | output | 32 | Counter value after the instruction |
| ctr_we | output | 1 | Counter is written with ctr_new |
| lr_we | output | 1 | Link register is written with lr_data |
| lr_data | output | 32 | Return address for the link register |
| predict | output | 1 | Static prediction: 1 means predicted taken |
| illegal | output | 1 | Instruction is not a valid branch form |

## Verification
The direct form is tried with a backward relative offset and with a forward absolute offset plus a link write. These two show sign extension apart from the absolute-address path. The conditional form is driven with each class of options code: condition-only with the selected bit clear and then set, decrement-and-test-non-zero with the counter at 5 and at 1, decrement-and-test-zero with the counter at 1 and at 0, decrement combined with a condition, and branch-always. Together these separate the counter sense, the condition sense, the update-before-test ordering and the counter wrap. The register forms are exercised with unaligned link and counter values, a decrementing branch to the link register, the forbidden decrementing branch to the counter, and an unknown opcode. The hint bit is set on a forward branch to show that it reverses the prediction.

// File: rtl/bru_pkg.sv
package bru_pkg;

    localparam int XLEN     = 32;
    localparam int OPC_W    = 6;
    localparam int OPT_W    = 5;
    localparam int SEL_W    = 5;
    localparam int SUB_W    = 10;
    localparam int LONG_W   = 24;
    localparam int SHORT_W  = 14;
    localparam int INSN_BYTES = 4;

    localparam logic [OPC_W-1:0] OPC_DIRECT = 6'd18;
    localparam logic [OPC_W-1:0] OPC_COND   = 6'd16;
    localparam logic [OPC_W-1:0] OPC_REG    = 6'd19;
    localparam logic [SUB_W-1:0] SUB_TO_LR  = 10'd16;
    localparam logic [SUB_W-1:0] SUB_TO_CTR = 10'd528;

    // Options code bit positions within the 5-bit field (LSB numbering)
    localparam int OPT_NO_COND  = 4;
    localparam int OPT_SENSE    = 3;
    localparam int OPT_NO_DEC   = 2;
    localparam int OPT_ON_ZERO  = 1;
    localparam int OPT_HINT     = 0;

    localparam logic [OPT_W-1:0] OPT_ALWAYS = 5'b10100;

    typedef enum logic [2:0] {
        BK_NONE,
        BK_DIRECT,
        BK_COND,
        BK_TO_LR,
        BK_TO_CTR
    } br_kind_e;

    typedef struct packed {
        br_kind_e          kind;
        logic [OPT_W-1:0]  opt;
        logic [SEL_W-1:0]  sel;
        logic              absolute;
        logic              link;
        logic [XLEN-1:0]   disp;
        logic              bad;
    } br_fields_t;

    typedef struct packed {
        logic              taken;
        logic [XLEN-1:0]   target;
        logic [XLEN-1:0]   ctr_new;
        logic              ctr_we;
        logic              lr_we;
        logic [XLEN-1:0]   lr_data;
        logic              predict;
        logic              illegal;
    } br_result_t;

    function automatic logic [XLEN-1:0] widen_long(input logic [LONG_W-1:0] off);
        return {{(XLEN-LONG_W-2){off[LONG_W-1]}}, off, 2'b00};
    endfunction

    function automatic logic [XLEN-1:0] widen_short(input logic [SHORT_W-1:0] off);
        return {{(XLEN-SHORT_W-2){off[SHORT_W-1]}}, off, 2'b00};
    endfunction

    // Condition bits are numbered from the most significant end
    function automatic logic pick_cr(input logic [XLEN-1:0] cr, input logic [SEL_W-1:0] sel);
        logic [SEL_W-1:0] idx;
        idx = 5'(XLEN-1) - sel;
        return cr[idx];
    endfunction

    function automatic logic [XLEN-1:0] word_align(input logic [XLEN-1:0] v);
        return v & ~XLEN'(INSN_BYTES-1);
    endfunction

endpackage

// File: rtl/bru_decode.sv
module bru_decode
    import bru_pkg::*;
(
    input  logic [XLEN-1:0] insn,
    output br_fields_t      f
);
    logic [OPC_W-1:0] opc;
    logic [SUB_W-1:0] sub;
    logic [4:0]       rsvd;

    assign opc  = insn[31:26];
    assign sub  = insn[10:1];
    assign rsvd = insn[15:11];

    always_comb begin
        f          = '0;
        f.kind     = BK_NONE;
        f.opt      = insn[25:21];
        f.sel      = insn[20:16];
        f.absolute = insn[1];
        f.link     = insn[0];
        case (opc)
            OPC_DIRECT: begin
                f.kind = BK_DIRECT;
                f.opt  = OPT_ALWAYS;
                f.sel  = '0;
                f.disp = widen_long(insn[25:2]);
            end
            OPC_COND: begin
                f.kind = BK_COND;
                f.disp = widen_short(insn[15:2]);
            end
            OPC_REG: begin
                if (rsvd == '0 && sub == SUB_TO_LR)
                    f.kind = BK_TO_LR;
                else if (rsvd == '0 && sub == SUB_TO_CTR)
                    f.kind = BK_TO_CTR;
            end
            default: f.kind = BK_NONE;
        endcase
        f.bad = (f.kind == BK_NONE) ||
                (f.kind == BK_TO_CTR && !f.opt[OPT_NO_DEC]);
    end
endmodule

// File: rtl/bru_cond.sv
module bru_cond
    import bru_pkg::*;
(
    input  br_kind_e         kind,
    input  logic [OPT_W-1:0] opt,
    input  logic [SEL_W-1:0] sel,
    input  logic             bad,
    input  logic [XLEN-1:0]  ctr,
    input  logic [XLEN-1:0]  cr,
    output logic             dec,
    output logic [XLEN-1:0]  ctr_next,
    output logic             go
);
    logic ctr_zero;
    logic ctr_ok;
    logic cond_ok;

    always_comb begin
        dec      = !bad && !opt[OPT_NO_DEC] &&
                   (kind == BK_COND || kind == BK_TO_LR);
        ctr_next = dec ? ctr - XLEN'(1) : ctr;
        ctr_zero = (ctr_next == '0);
        ctr_ok   = opt[OPT_NO_DEC] || (ctr_zero == opt[OPT_ON_ZERO]);
        cond_ok  = opt[OPT_NO_COND] || (pick_cr(cr, sel) == opt[OPT_SENSE]);
        go       = !bad && ctr_ok && cond_ok;
    end
endmodule

// File: rtl/bru_target.sv
module bru_target
    import bru_pkg::*;
(
    input  br_kind_e        kind,
    input  logic            always_br,
    input  logic            hint,
    input  logic            absolute,
    input  logic [XLEN-1:0] disp,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] ctr,
    input  logic [XLEN-1:0] lr,
    output logic [XLEN-1:0] dest,
    output logic [XLEN-1:0] ret_addr,
    output logic            guess
);
    logic [XLEN-1:0] imm_dest;

    always_comb begin
        imm_dest = absolute ? disp : pc + disp;
        ret_addr = pc + XLEN'(INSN_BYTES);
        case (kind)
            BK_DIRECT: begin
                dest  = imm_dest;
                guess = 1'b1;
            end
            BK_COND: begin
                dest  = imm_dest;
                guess = always_br ? 1'b1 : (disp[XLEN-1] ^ hint);
            end
            BK_TO_LR: begin
                dest  = word_align(lr);
                guess = always_br ? 1'b1 : hint;
            end
            BK_TO_CTR: begin
                dest  = word_align(ctr);
                guess = always_br ? 1'b1 : hint;
            end
            default: begin
                dest  = ret_addr;
                guess = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/bru_unit.sv
module bru_unit
    import bru_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [XLEN-1:0] insn,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] ctr,
    input  logic [XLEN-1:0] lr,
    input  logic [XLEN-1:0] cr,
    output logic            out_valid,
    output logic            taken,
    output logic [XLEN-1:0] target,
    output logic [XLEN-1:0] ctr_new,
    output logic            ctr_we,
    output logic            lr_we,
    output logic [XLEN-1:0] lr_data,
    output logic            predict,
    output logic            illegal
);
    br_fields_t      f;
    br_result_t      nxt;
    br_result_t      res;
    logic            dec;
    logic            go;
    logic            guess;
    logic [XLEN-1:0] ctr_next;
    logic [XLEN-1:0] dest;
    logic [XLEN-1:0] ret_addr;
    logic            valid_q;

    bru_decode u_decode (
        .insn (insn),
        .f    (f)
    );

    bru_cond u_cond (
        .kind     (f.kind),
        .opt      (f.opt),
        .sel      (f.sel),
        .bad      (f.bad),
        .ctr      (ctr),
        .cr       (cr),
        .dec      (dec),
        .ctr_next (ctr_next),
        .go       (go)
    );

    bru_target u_target (
        .kind      (f.kind),
        .always_br (f.opt[OPT_NO_COND] & f.opt[OPT_NO_DEC]),
        .hint      (f.opt[OPT_HINT]),
        .absolute  (f.absolute),
        .disp      (f.disp),
        .pc        (pc),
        .ctr       (ctr),
        .lr        (lr),
        .dest      (dest),
        .ret_addr  (ret_addr),
        .guess     (guess)
    );

    always_comb begin
        nxt.taken   = go;
        nxt.target  = dest;
        nxt.ctr_new = ctr_next;
        nxt.ctr_we  = dec;
        nxt.lr_we   = f.link && !f.bad;
        nxt.lr_data = ret_addr;
        nxt.predict = guess && !f.bad;
        nxt.illegal = f.bad;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res     <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                res <= nxt;
            end else begin
                res.taken   <= 1'b0;
                res.ctr_we  <= 1'b0;
                res.lr_we   <= 1'b0;
                res.illegal <= 1'b0;
            end
        end
    end

    assign out_valid = valid_q;
    assign taken     = res.taken;
    assign target    = res.target;
    assign ctr_new   = res.ctr_new;
    assign ctr_we    = res.ctr_we;
    assign lr_we     = res.lr_we;
    assign lr_data   = res.lr_data;
    assign predict   = res.predict;
    assign illegal   = res.illegal;
endmodule

// File: rtl/bru_unit_chk.sv
module bru_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [5:0]  opc,
    input logic [9:0]  sub,
    input logic [31:0] pc,
    input logic [31:0] ctr,
    input logic [31:0] lr,
    input logic        out_valid,
    input logic        taken,
    input logic [31:0] target,
    input logic [31:0] ctr_new,
    input logic        ctr_we,
    input logic        lr_we,
    input logic [31:0] lr_data,
    input logic        predict,
    input logic        illegal
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!taken && !ctr_we && !lr_we && !illegal));

    a_r2_strobe_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r3_direct_always: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(opc) == 6'd18) |-> (taken && predict && !ctr_we));

    a_r5_dec_value: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ctr_we) |-> (ctr_new == $past(ctr) - 32'd1));

    a_r5_hold_value: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !ctr_we) |-> (ctr_new == $past(ctr)));

    a_r8_return_addr: assert property (@(posedge clk) disable iff (rst)
        (out_valid && lr_we) |-> (lr_data == $past(pc) + 32'd4));

    a_r9_lr_target: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !illegal && $past(opc) == 6'd19 && $past(sub) == 10'd16)
        |-> (target == {$past(lr[31:2]), 2'b00}));

    a_r10_illegal_inert: assert property (@(posedge clk) disable iff (rst)
        (out_valid && illegal) |-> (!taken && !ctr_we && !lr_we));
endmodule

bind bru_unit bru_unit_chk i_bru_unit_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .opc       (insn[31:26]),
    .sub       (insn[10:1]),
    .pc        (pc),
    .ctr       (ctr),
    .lr        (lr),
    .out_valid (out_valid),
    .taken     (taken),
    .target    (target),
    .ctr_new   (ctr_new),
    .ctr_we    (ctr_we),
    .lr_we     (lr_we),
    .lr_data   (lr_data),
    .predict   (predict),
    .illegal   (illegal)
);

// File: tb/test_bru_unit.sv
`timescale 1ns/1ps
module test_bru_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] insn, pc, ctr, lr, cr;
    logic        out_valid, taken, ctr_we, lr_we, predict, illegal;
    logic [31:0] target, ctr_new, lr_data;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    bru_unit i_bru_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn), .pc(pc),
        .ctr(ctr), .lr(lr), .cr(cr), .out_valid(out_valid), .taken(taken),
        .target(target), .ctr_new(ctr_new), .ctr_we(ctr_we), .lr_we(lr_we),
        .lr_data(lr_data), .predict(predict), .illegal(illegal)
    );

    function automatic logic [31:0] enc_direct(logic [23:0] off, logic aa, logic lk);
        return {6'd18, off, aa, lk};
    endfunction
    function automatic logic [31:0] enc_cond(logic [4:0] bo, logic [4:0] bi,
                                             logic [13:0] off, logic aa, logic lk);
        return {6'd16, bo, bi, off, aa, lk};
    endfunction
    function automatic logic [31:0] enc_reg(logic [4:0] bo, logic [9:0] sub, logic lk);
        return {6'd19, bo, 5'd0, 5'd0, sub, lk};
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic issue(logic [31:0] i, logic [31:0] p, logic [31:0] c,
                         logic [31:0] l, logic [31:0] k);
        @(negedge clk);
        insn = i; pc = p; ctr = c; lr = l; cr = k; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Checks the registered result; target and lr_data only where meaningful
    task automatic expect_out(string req, logic tk, logic use_tgt, logic [31:0] tgt,
                              logic [31:0] cn, logic cwe, logic lwe, logic [31:0] ld,
                              logic pr, logic ill);
        chk(req, "out_valid", 32'(out_valid), 32'd1);
        chk(req, "taken",     32'(taken),     32'(tk));
        if (use_tgt) chk(req, "target", target, tgt);
        chk(req, "ctr_new",   ctr_new,        cn);
        chk(req, "ctr_we",    32'(ctr_we),    32'(cwe));
        chk(req, "lr_we",     32'(lr_we),     32'(lwe));
        if (lwe) chk(req, "lr_data", lr_data, ld);
        chk(req, "predict",   32'(predict),   32'(pr));
        chk(req, "illegal",   32'(illegal),   32'(ill));
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0;
        insn = '0; pc = '0; ctr = '0; lr = '0; cr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1", "out_valid", 32'(out_valid), 0);
        chk("R1", "taken",     32'(taken),     0);
        chk("R1", "lr_we",     32'(lr_we),     0);
        chk("R1", "ctr_we",    32'(ctr_we),    0);
        chk("R1", "illegal",   32'(illegal),   0);
    endtask

    task automatic t_direct();
        // R3 backward relative, -4 words
        issue(enc_direct(24'hFFFFFC, 0, 0), 32'h1000, 32'd9, 32'h0, 32'h0);
        expect_out("R3", 1, 1, 32'h0FF0, 32'd9, 0, 0, 0, 1, 0);
        // R3 absolute with link (R8)
        issue(enc_direct(24'h000040, 1, 1), 32'h4000, 32'd9, 32'h0, 32'h0);
        expect_out("R3/R8", 1, 1, 32'h0100, 32'd9, 0, 1, 32'h4004, 1, 0);
    endtask

    task automatic t_cond_only();
        // R6 condition-only, bit false needed, cr bit 2 (cr[29]) clear
        issue(enc_cond(5'b00100, 5'd2, 14'd8, 0, 0), 32'h2000, 32'd7, 0, 32'h0);
        expect_out("R6/R4", 1, 1, 32'h2020, 32'd7, 0, 0, 0, 0, 0);
        issue(enc_cond(5'b00100, 5'd2, 14'd8, 0, 0), 32'h2000, 32'd7, 0, 32'h2000_0000);
        expect_out("R6", 0, 0, 0, 32'd7, 0, 0, 0, 0, 0);
        // R4 absolute conditional
        issue(enc_cond(5'b00100, 5'd2, 14'd8, 1, 0), 32'h2000, 32'd7, 0, 32'h0);
        expect_out("R4", 1, 1, 32'h0020, 32'd7, 0, 0, 0, 0, 0);
        // R11 hint bit reverses a forward prediction
        issue(enc_cond(5'b00101, 5'd2, 14'd8, 0, 0), 32'h2000, 32'd7, 0, 32'h0);
        expect_out("R11", 1, 1, 32'h2020, 32'd7, 0, 0, 0, 1, 0);
    endtask

    task automatic t_counter();
        // R5 R7 decrement, branch non-zero, backward -2 words
        issue(enc_cond(5'b10000, 5'd0, 14'h3FFE, 0, 0), 32'h3000, 32'd5, 0, 0);
        expect_out("R5/R7", 1, 1, 32'h2FF8, 32'd4, 1, 0, 0, 1, 0);
        issue(enc_cond(5'b10000, 5'd0, 14'h3FFE, 0, 0), 32'h3000, 32'd1, 0, 0);
        expect_out("R7", 0, 0, 0, 32'd0, 1, 0, 0, 1, 0);
        // R7 branch when zero after decrement
        issue(enc_cond(5'b10010, 5'd0, 14'd4, 0, 0), 32'h3000, 32'd1, 0, 0);
        expect_out("R7", 1, 1, 32'h3010, 32'd0, 1, 0, 0, 0, 0);
        // R5 wrap from zero
        issue(enc_cond(5'b10010, 5'd0, 14'd4, 0, 0), 32'h3000, 32'd0, 0, 0);
        expect_out("R5", 0, 0, 0, 32'hFFFF_FFFF, 1, 0, 0, 0, 0);
        // R6 with decrement: bit 0 is cr[31], needs 1
        issue(enc_cond(5'b01000, 5'd0, 14'd4, 0, 0), 32'h3000, 32'd3, 0, 32'h8000_0000);
        expect_out("R6/R5", 1, 1, 32'h3010, 32'd2, 1, 0, 0, 0, 0);
        issue(enc_cond(5'b01000, 5'd0, 14'd4, 0, 0), 32'h3000, 32'd3, 0, 32'h0);
        expect_out("R6/R5", 0, 0, 0, 32'd2, 1, 0, 0, 0, 0);
    endtask

    task automatic t_always_link();
        // R8 R11 branch-always with link, forward yet predicted taken
        issue(enc_cond(5'b10100, 5'd0, 14'd8, 0, 1), 32'h0500, 32'd6, 0, 0);
        expect_out("R8/R11", 1, 1, 32'h0520, 32'd6, 0, 1, 32'h0504, 1, 0);
        // R8 link written even when not taken
        issue(enc_cond(5'b00100, 5'd2, 14'd8, 0, 1), 32'h0500, 32'd6, 0, 32'h2000_0000);
        expect_out("R8", 0, 0, 0, 32'd6, 0, 1, 32'h0504, 0, 0);
    endtask

    task automatic t_register();
        // R9 to link register, old value used, low bits cleared
        issue(enc_reg(5'b10100, 10'd16, 1), 32'h0600, 32'd4, 32'h2003, 0);
        expect_out("R9", 1, 1, 32'h2000, 32'd4, 0, 1, 32'h0604, 1, 0);
        // R9 to counter register
        issue(enc_reg(5'b10100, 10'd528, 0), 32'h0600, 32'h3007, 32'h0, 0);
        expect_out("R9", 1, 1, 32'h3004, 32'h3007, 0, 0, 0, 1, 0);
        // R9 R5 decrementing branch to link register
        issue(enc_reg(5'b10000, 10'd16, 0), 32'h0600, 32'd2, 32'h7000, 0);
        expect_out("R9/R5", 1, 1, 32'h7000, 32'd1, 1, 0, 0, 0, 0);
    endtask

    task automatic t_illegal();
        // R10 decrementing branch to counter
        issue(enc_reg(5'b10000, 10'd528, 1), 32'h0700, 32'd2, 32'h0, 0);
        expect_out("R10", 0, 0, 0, 32'd2, 0, 0, 0, 0, 1);
        // R10 foreign major opcode
        issue({6'd31, 26'h0000001}, 32'h0700, 32'd2, 32'h0, 0);
        expect_out("R10", 0, 0, 0, 32'd2, 0, 0, 0, 0, 1);
        // R10 unknown register sub-code
        issue(enc_reg(5'b10100, 10'd99, 0), 32'h0700, 32'd2, 32'h0, 0);
        expect_out("R10", 0, 0, 0, 32'd2, 0, 0, 0, 0, 1);
    endtask

    task automatic t_gap();
        // R2 R1 no strobe: no output strobe and no side effects
        @(negedge clk);
        insn = enc_direct(24'd4, 0, 1);
        @(negedge clk);
        chk("R2", "out_valid idle", 32'(out_valid), 0);
        chk("R1", "lr_we idle",     32'(lr_we),     0);
        chk("R1", "taken idle",     32'(taken),     0);
    endtask

    initial begin
        t_reset();
        t_direct();
        t_cond_only();
        t_counter();
        t_always_link();
        t_register();
        t_illegal();
        t_gap();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule